// File: doc/BRIEF.md
# Privilege-Gated Performance Counter Register File

This block keeps the hart's machine-level counters: one that advances on every clock, one that advances on each retired-instruction pulse, and a parameterised bank of event counters that each advance on their own pulse input. Each counter is 64 bits wide. Software reaches the counters through a 12-bit register address, together with the current privilege level and a read or write request. The block answers in the same cycle with read data, or with an illegal-instruction flag that the trap logic elsewhere turns into an exception.

A read-only view of each counter sits in the unprivileged address region. A further view in that region returns an externally supplied 64-bit real-time value. A machine-level enable register decides, counter by counter, whether supervisor or user code may read these views. Machine code always reads them. `XLEN` selects a 32-bit or a 64-bit register interface. In the 32-bit build, the upper halves are reached through separate high-half addresses. `HAS_SHADOW` decides whether the unprivileged views exist at all.

Top module: `perfctr_csr_file`

## Requirements
- R1: The cycle counter (address 0xB00, index 0) advances by one on every clock edge, unless a legal write to it lands on that edge.
- R2: The retired-instruction counter (0xB02) advances by one on each edge where `retire` is high. Event counter k (address 0xB03+k) advances on each edge where `hpm_event[k]` is high.
- R3: A legal write to a counter stores the written value on that edge, and that edge's increment is dropped.
- R4: From machine mode (priv 2'b11), the unprivileged view at 0xC00+n reads the same value as the counter at 0xB00+n.
- R5: From supervisor (2'b01) or user (2'b00) mode, a read of view 0xC00+n flags illegal while bit n of the enable register (0x306) is clear. Bit 0 covers the cycle view, bit 1 the time view, bit 2 the retired-instruction view, and bit 3+k event view k.
- R6: Any access whose address bits 9:8 exceed the current privilege level flags illegal.
- R7: A write to any address whose bits 11:10 are 2'b11 flags illegal and changes no state.
- R8: With XLEN=32, addresses 0xB80+n and 0xC80+n read and write bits 63:32 of the counter, and the base addresses reach bits 31:0. With XLEN=64, the base addresses reach all 64 bits, and every high-half address flags illegal.
- R9: With HAS_SHADOW=0, every address in 0xC00–0xCFF flags illegal, including from machine mode.
- R10: The time view (0xC01, high half 0xC81) returns `time_in`.
- R11: After reset, all counters and the enable register are zero.
- R12: An address that names no implemented register (for example 0xB01, or an event counter beyond NUM_HPM) flags illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | Access request this cycle |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| priv | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| retire | input | 1 | Instruction-retired pulse |
| hpm_event | input | NUM_HPM | Event pulses, one per event counter |
| time_in | input | 64 | Real-time value |
| csr_rdata | output | XLEN | Read data (zero when illegal or idle) |
| csr_illegal | output | 1 | Illegal-instruction flag for the current request |

## Verification
On every cycle, the assertions check the following:
- the step of the cycle and retired-instruction counters;
- that a write wins over an increment;
- the privilege floor and the read-only region;
- that enable-bit gating applies to lower-mode reads;
- the time view;
- the illegal flag on addresses that the build leaves out.

Only the bench scenarios can show certain things: a counter taking exact values across a sequence of writes and pulses; high-half data landing in the right bits; a refused write leaving the counter on its expected count; and the contrast between a 32-bit build with views and a 64-bit build without them.

// File: rtl/perfctr_pkg.sv
package perfctr_pkg;
   localparam logic [1:0] PRIV_U = 2'b00;
   localparam logic [1:0] PRIV_S = 2'b01;
   localparam logic [1:0] PRIV_M = 2'b11;

   localparam logic [3:0]  PAGE_MCTR   = 4'hB;
   localparam logic [3:0]  PAGE_UVIEW  = 4'hC;
   localparam logic [11:0] ADDR_CTR_EN = 12'h306;

   localparam int unsigned SLOT_CYCLE = 0;
   localparam int unsigned SLOT_TIME  = 1;
   localparam int unsigned SLOT_RET   = 2;
   localparam int unsigned SLOT_EVT0  = 3;

   typedef struct packed {
      logic       illegal;
      logic       hit_ctr;
      logic       hit_time;
      logic       hit_en;
      logic       hi;
      logic [4:0] idx;
   } dec_t;
endpackage

// File: rtl/pc_csr_decode.sv
module pc_csr_decode
   import perfctr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NUM_HPM    = 4,
   parameter bit HAS_SHADOW = 1
)(
   input  logic        req,
   input  logic        we,
   input  logic [11:0] addr,
   input  logic [1:0]  priv,
   input  logic [31:0] en_bits,
   output dec_t        dec
);
   localparam int SLOT_END = int'(SLOT_EVT0) + NUM_HPM;

   logic [4:0] slot;
   logic       slot_ctr, half_ok, is_view, gated, known;

   always_comb begin
      slot     = addr[4:0];
      slot_ctr = (addr[6:5] == 2'b00) &&
                 ((int'(slot) == int'(SLOT_CYCLE)) || (int'(slot) == int'(SLOT_RET)) ||
                  ((int'(slot) >= int'(SLOT_EVT0)) && (int'(slot) < SLOT_END)));
      half_ok  = !addr[7] || (XLEN == 32);
      dec      = '0;
      is_view  = 1'b0;
      dec.hi   = addr[7];
      if (slot == 5'd0)      dec.idx = 5'd0;
      else if (slot == 5'd2) dec.idx = 5'd1;
      else                   dec.idx = slot - 5'd1;
      case (addr[11:8])
         PAGE_MCTR:  dec.hit_ctr = slot_ctr && half_ok;
         PAGE_UVIEW: begin
            if (HAS_SHADOW && half_ok) begin
               is_view      = 1'b1;
               dec.hit_ctr  = slot_ctr;
               dec.hit_time = (addr[6:5] == 2'b00) && (int'(slot) == int'(SLOT_TIME));
            end
         end
         default:    dec.hit_en = (addr == ADDR_CTR_EN);
      endcase
      known       = dec.hit_ctr || dec.hit_time || dec.hit_en;
      gated       = is_view && (priv != PRIV_M) && !en_bits[slot];
      dec.illegal = req && (!known || (priv < addr[9:8]) ||
                            (we && (addr[11:10] == 2'b11)) || gated);
   end
endmodule

// File: rtl/pc_counter.sv
module pc_counter (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        inc,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [63:0] wdata,
   output logic [63:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_lo || wr_hi) begin
         if (wr_lo) q[31:0]  <= wdata[31:0];
         if (wr_hi) q[63:32] <= wdata[63:32];
      end else if (inc) begin
         q <= q + 64'd1;
      end
   end
endmodule

// File: rtl/perfctr_csr_file.sv
module perfctr_csr_file
   import perfctr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NUM_HPM    = 4,
   parameter bit HAS_SHADOW = 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csr_req,
   input  logic               csr_we,
   input  logic [11:0]        csr_addr,
   input  logic [XLEN-1:0]    csr_wdata,
   input  logic [1:0]         priv,
   input  logic               retire,
   input  logic [NUM_HPM-1:0] hpm_event,
   input  logic [63:0]        time_in,
   output logic [XLEN-1:0]    csr_rdata,
   output logic               csr_illegal
);
   localparam int NC = 2 + NUM_HPM;
   localparam int EW = int'(SLOT_EVT0) + NUM_HPM;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("perfctr_csr_file: XLEN must be 32 or 64");
      end
      if (NUM_HPM < 1 || NUM_HPM > 28) begin : g_bad_hpm
         $error("perfctr_csr_file: NUM_HPM must be 1..28");
      end
   endgenerate

   dec_t          dec;
   logic [EW-1:0] en_q;
   logic [31:0]   en_ext;
   logic [63:0]   ctr_q [NC];
   logic [NC-1:0] inc_v, wr_lo, wr_hi;
   logic [63:0]   wdata64, sel64, rfull;
   logic          do_wr;

   assign en_ext = {{(32-EW){1'b0}}, en_q};

   pc_csr_decode #(.XLEN(XLEN), .NUM_HPM(NUM_HPM), .HAS_SHADOW(HAS_SHADOW)) u_dec (
      .req(csr_req), .we(csr_we), .addr(csr_addr), .priv(priv),
      .en_bits(en_ext), .dec(dec)
   );

   assign do_wr = csr_req && csr_we && !dec.illegal;

   generate
      if (XLEN == 64) begin : g_wd64
         assign wdata64 = 64'(csr_wdata);
      end else begin : g_wd32
         assign wdata64 = {2{csr_wdata[31:0]}};
      end
   endgenerate

   assign inc_v = {hpm_event, retire, 1'b1};

   generate
      for (genvar i = 0; i < NC; i++) begin : g_ctr
         assign wr_lo[i] = do_wr && dec.hit_ctr && (int'(dec.idx) == i) &&
                           ((XLEN == 64) || !dec.hi);
         assign wr_hi[i] = do_wr && dec.hit_ctr && (int'(dec.idx) == i) &&
                           ((XLEN == 64) || dec.hi);
         pc_counter u_ctr (
            .clk(clk), .rst_n(rst_n), .inc(inc_v[i]),
            .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(wdata64), .q(ctr_q[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    en_q <= '0;
      else if (do_wr && dec.hit_en)  en_q <= csr_wdata[EW-1:0];
   end

   always_comb begin
      sel64 = time_in;
      if (!dec.hit_time) begin
         sel64 = '0;
         for (int i = 0; i < NC; i++)
            if (int'(dec.idx) == i) sel64 = ctr_q[i];
      end
      if (dec.hit_en)  rfull = {32'b0, en_ext};
      else if (dec.hi) rfull = {32'b0, sel64[63:32]};
      else             rfull = sel64;
      if (!csr_req || dec.illegal) rfull = '0;
   end

   assign csr_rdata   = rfull[XLEN-1:0];
   assign csr_illegal = dec.illegal;
endmodule

// File: rtl/perfctr_csr_file_chk.sv
module perfctr_csr_file_chk
   import perfctr_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NUM_HPM    = 4,
   parameter bit HAS_SHADOW = 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              csr_req,
   input logic              csr_we,
   input logic [11:0]       csr_addr,
   input logic [XLEN-1:0]   csr_wdata,
   input logic [1:0]        priv,
   input logic              retire,
   input logic [63:0]       time_in,
   input logic [XLEN-1:0]   csr_rdata,
   input logic              csr_illegal,
   input logic [63:0]       cyc_val,
   input logic [63:0]       ir_val,
   input logic [31:0]       en_ext,
   input logic [NUM_HPM+1:0] wr_lo,
   input logic [NUM_HPM+1:0] wr_hi
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;

   assert_cycle_step_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(wr_lo[0] || wr_hi[0]) |-> cyc_val == $past(cyc_val) + 64'd1);

   assert_retire_step_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(wr_lo[1] || wr_hi[1]) |-> ir_val == $past(ir_val) + 64'($past(retire)));

   assert_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && csr_we && !csr_illegal && csr_addr == 12'hB02)
      |=> ir_val[31:0] == $past(csr_wdata[31:0]));

   assert_lowpriv_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && priv != PRIV_M && csr_addr[11:8] == PAGE_UVIEW &&
       !en_ext[csr_addr[4:0]]) |-> csr_illegal);

   assert_priv_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && priv < csr_addr[9:8]) |-> csr_illegal);

   assert_ro_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && csr_we && csr_addr[11:10] == 2'b11) |-> csr_illegal);

   assert_ro_enable_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && csr_we && csr_addr[11:10] == 2'b11) |=> $stable(en_ext));

   assert_time_view_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && !csr_we && csr_addr == 12'hC01 && !csr_illegal)
      |-> csr_rdata == time_in[XLEN-1:0]);

   generate
      if (HAS_SHADOW) begin : g_view
         assert_mview_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_req && !csr_we && priv == PRIV_M && csr_addr == 12'hC00)
            |-> (!csr_illegal && csr_rdata == cyc_val[XLEN-1:0]));
      end else begin : g_noview
         assert_view_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_req && csr_addr[11:8] == PAGE_UVIEW) |-> csr_illegal);
      end
      if (XLEN == 64) begin : g_nohigh
         assert_no_high_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (csr_req && csr_addr[11:8] == PAGE_MCTR && csr_addr[7]) |-> csr_illegal);
      end
   endgenerate

   assert_unknown_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && csr_addr == 12'hB01) |-> csr_illegal);
endmodule

bind perfctr_csr_file perfctr_csr_file_chk #(
   .XLEN(XLEN), .NUM_HPM(NUM_HPM), .HAS_SHADOW(HAS_SHADOW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
   .csr_addr(csr_addr), .csr_wdata(csr_wdata), .priv(priv), .retire(retire),
   .time_in(time_in), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
   .cyc_val(ctr_q[0]), .ir_val(ctr_q[1]), .en_ext(en_ext),
   .wr_lo(wr_lo), .wr_hi(wr_hi)
);

// File: tb/perfctr_csr_file_bench.sv
module perfctr_csr_file_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NHPM = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [11:0] addr = '0;
   logic [63:0] wdata = '0;
   logic [1:0]  priv = 2'b11;
   logic        retire = 1'b0;
   logic [NHPM-1:0] hpm_event = '0;
   logic [63:0] time_in = 64'h0000_00AB_1234_5678;
   logic [31:0] rd_main;
   logic        ill_main;
   logic [63:0] rd_alt;
   logic        ill_alt;
   logic [31:0] s_rd;
   logic        s_ill;
   logic [63:0] s_rd_alt;
   logic        s_ill_alt;
   int          n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   perfctr_csr_file #(.XLEN(32), .NUM_HPM(NHPM), .HAS_SHADOW(1)) u_perfctr_csr_file (
      .clk(clk), .rst_n(rst_n), .csr_req(req), .csr_we(we), .csr_addr(addr),
      .csr_wdata(wdata[31:0]), .priv(priv), .retire(retire), .hpm_event(hpm_event),
      .time_in(time_in), .csr_rdata(rd_main), .csr_illegal(ill_main)
   );

   perfctr_csr_file #(.XLEN(64), .NUM_HPM(NHPM), .HAS_SHADOW(0)) u_perfctr_csr_file_alt (
      .clk(clk), .rst_n(rst_n), .csr_req(req), .csr_we(we), .csr_addr(addr),
      .csr_wdata(wdata), .priv(priv), .retire(retire), .hpm_event(hpm_event),
      .time_in(time_in), .csr_rdata(rd_alt), .csr_illegal(ill_alt)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic access(input logic w, input logic [11:0] a, input logic [63:0] d,
                         input logic [1:0] p);
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d; priv = p;
      #1;
      s_rd = rd_main; s_ill = ill_main; s_rd_alt = rd_alt; s_ill_alt = ill_alt;
      @(posedge clk);
      #1 req = 1'b0; we = 1'b0;
   endtask

   task automatic t_reset();
      access(0, 12'h306, 0, 2'b11); check("R11 enable reg after reset", s_rd, 0);
      access(0, 12'hB02, 0, 2'b11); check("R11 instret after reset", s_rd, 0);
      access(0, 12'hB03, 0, 2'b11); check("R11 event counter after reset", s_rd, 0);
   endtask

   task automatic t_cycle();
      access(1, 12'hB00, 64'd100, 2'b11);
      access(0, 12'hB00, 0, 2'b11); check("R3 cycle write value", s_rd, 100);
      access(0, 12'hC00, 0, 2'b11); check("R1 R4 M-mode cycle view one edge later", s_rd, 101);
      check("R4 M-mode view legal", s_ill, 0);
   endtask

   task automatic t_counts();
      access(1, 12'hB02, 0, 2'b11);
      @(negedge clk); retire = 1'b1;
      repeat (3) @(posedge clk);
      #1 retire = 1'b0;
      access(0, 12'hB02, 0, 2'b11); check("R2 instret after 3 pulses", s_rd, 3);
      @(negedge clk); hpm_event = 4'b0010;
      repeat (2) @(posedge clk);
      #1 hpm_event = '0;
      access(0, 12'hB04, 0, 2'b11); check("R2 event counter 1 after 2 pulses", s_rd, 2);
      access(0, 12'hB03, 0, 2'b11); check("R2 event counter 0 untouched", s_rd, 0);
   endtask

   task automatic t_priority();
      @(negedge clk); retire = 1'b1;
      access(1, 12'hB02, 64'd50, 2'b11);
      retire = 1'b0;
      access(0, 12'hB02, 0, 2'b11); check("R3 write beats increment", s_rd, 50);
   endtask

   task automatic t_gate();
      access(0, 12'hC00, 0, 2'b00); check("R5 U cycle view gated", s_ill, 1);
      access(0, 12'hC02, 0, 2'b01); check("R5 S instret view gated", s_ill, 1);
      access(1, 12'h306, 64'h5, 2'b11);
      access(0, 12'hC00, 0, 2'b00); check("R5 U cycle view enabled", s_ill, 0);
      access(0, 12'hC02, 0, 2'b00); check("R5 U instret view value", s_rd, 50);
      access(0, 12'hC01, 0, 2'b00); check("R5 U time view gated", s_ill, 1);
      access(0, 12'hC03, 0, 2'b01); check("R5 S event view gated", s_ill, 1);
      access(1, 12'h306, 64'h7, 2'b11);
      access(0, 12'hC01, 0, 2'b00); check("R10 U time view low", s_rd, 32'h1234_5678);
      access(0, 12'hC81, 0, 2'b11); check("R10 R8 time high half", s_rd, 32'hAB);
   endtask

   task automatic t_privfloor();
      access(0, 12'hB00, 0, 2'b00); check("R6 U read of machine counter", s_ill, 1);
      access(1, 12'h306, 64'h0, 2'b01); check("R6 S write of enable reg", s_ill, 1);
      access(0, 12'h306, 0, 2'b11); check("R6 enable reg unchanged", s_rd, 7);
   endtask

   task automatic t_readonly();
      access(1, 12'hB00, 64'd1000, 2'b11);
      access(1, 12'hC00, 64'd7, 2'b11); check("R7 view write flagged", s_ill, 1);
      access(0, 12'hB00, 0, 2'b11); check("R7 cycle not written by view write", s_rd, 1001);
   endtask

   task automatic t_high();
      access(1, 12'hB80, 64'd9, 2'b11);
      access(0, 12'hC80, 0, 2'b11); check("R8 cycle high via view", s_rd, 9);
      access(1, 12'hB82, 64'd3, 2'b11);
      access(0, 12'hB82, 0, 2'b11); check("R8 instret high", s_rd, 3);
      access(0, 12'hB02, 0, 2'b11); check("R8 instret low kept", s_rd, 50);
      access(0, 12'hB80, 0, 2'b11); check("R8 64-bit build high half illegal", s_ill_alt, 1);
      access(1, 12'hB02, 64'h0000_0002_0000_0010, 2'b11);
      access(0, 12'hB02, 0, 2'b11);
      check("R8 64-bit build full width", s_rd_alt, 64'h0000_0002_0000_0010);
      check("R8 32-bit build low only", s_rd, 32'h10);
   endtask

   task automatic t_absent();
      access(0, 12'hC00, 0, 2'b11); check("R9 view absent from M", s_ill_alt, 1);
      access(0, 12'hC01, 0, 2'b11); check("R9 time view absent", s_ill_alt, 1);
      access(0, 12'hB01, 0, 2'b11); check("R12 hole at 0xB01", s_ill, 1);
      access(0, 12'hB07, 0, 2'b11); check("R12 event counter past NUM_HPM", s_ill, 1);
      check("R12 illegal read data zero", s_rd, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cycle();
      t_counts();
      t_priority();
      t_gate();
      t_privfloor();
      t_readonly();
      t_high();
      t_absent();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule